// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the control state machine for a single DMA channel. It keeps track of four pieces of channel state: whether the channel is enabled, whether it is active (requesting the transfer engine), whether one hardware request is held pending, and whether it is parked waiting for software to finish reprogramming. It reacts to writes of the channel control word, to hardware request lines, to a link-enable input from a neighbouring channel, and to end-of-element, end-of-frame and end-of-block events reported by the datapath.

Its outputs are the transfer request level and one-cycle strobes. The strobes tell the datapath to reload its working address set, report activation and deactivation, and ask another channel to start when this one finishes a block in chained mode. It also keeps a sticky dropped-request flag and a synchronised-transfer flag.

A channel runs in one of three synchronisation granularities. With the frame-sync bit clear and the block-sync input low, one hardware request moves one element. With frame-sync set and block-sync low, one request moves one frame. With both set, one request moves one block. A sync line number of zero means the channel is free-running and not paced by hardware.

Top module: `dma_chan_ctrl`

## Requirements
- R1: During and right after reset, every state output and every strobe is 0.
- R2: A control write with bit 7 set, or a pulse on `link_in`, enables a disabled channel. In the following cycle `chan_en` and `load_stb` are 1 and `wait_o` is 0. `xfer_req` also rises in that cycle if the sync field (bits 4:0) is 0 or the selected request line is already high; otherwise the channel stays inactive.
- R3: On an enabled channel with a nonzero sync field, a rising edge on the selected request line activates the channel if it is inactive (`act_stb` pulses). If the channel is already active and has nothing pending, the edge sets `pend_o`.
- R4: A rising edge that arrives while `pend_o` is already 1 sets `drop_flag`. The flag stays set until a cycle with `stat_clr` high.
- R5: A synchronised active channel deactivates when it sees the event that matches its granularity. With frame-sync (bit 5) = 0 and `cfg_bs` = 0 that event is `ev_elem`; with frame-sync = 1 and `cfg_bs` = 0 it is `ev_frame`; with both set it is `ev_block`. An unsynchronised channel does not deactivate on these events.
- R6: A deactivation on a channel that has a pending request, is still enabled and is not waiting consumes the pending request. The channel stays active, `pend_o` clears, `act_stb` pulses and `deact_stb` stays 0.
- R7: At end of block with compatibility-disable (bit 10) set, the channel disables itself. If `link_on` is also high, it pulses `link_stb` with `link_ch` equal to `link_sel`.
- R8: At end of block without compatibility-disable, the outcome depends on auto-init (bit 8), repeat (bit 9) and end-of-programming (bit 11). With auto-init clear the channel disables. With auto-init set and either repeat or end-of-programming set, it pulses `load_stb` and keeps running. With auto-init set and neither of the other two set, it sets `wait_o` and deactivates.
- R9: A control write with bit 11 set while `wait_o` is 1 clears `wait_o`. The channel then activates if its sync field is 0 or a request is pending; otherwise it stays inactive.
- R10: `sync_flag` rises with any activation when the sync field is nonzero and falls on deactivation. It is never 1 while `xfer_req` is 0.
- R11: A control write with bit 7 clear on an enabled channel clears `chan_en` and `pend_o` and drops `xfer_req` in the same cycle, with no reactivation afterwards.
- R12: Edges on request lines other than the selected one, and any edge while the channel is disabled, leave the channel state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: [15:14] dst mode, [13:12] src mode, [11] end-of-programming, [10] compatibility-disable, [9] repeat, [8] auto-init, [7] enable, [6] priority, [5] frame-sync, [4:0] sync line |
| link_in | input | 1 | Enable request arriving from a chained channel |
| cfg_bs | input | 1 | Block-sync setting from the channel options register |
| link_on | input | 1 | Chaining enabled |
| link_sel | input | LINK_W | Channel to start at end of block |
| req_lines | input | N_LINES-1 | Hardware request lines, indexed 1 to N_LINES-1 |
| ev_elem | input | 1 | Datapath finished an element |
| ev_frame | input | 1 | Datapath finished a frame |
| ev_block | input | 1 | Datapath finished a block |
| stat_clr | input | 1 | Clears the dropped-request flag |
| chan_en | output | 1 | Channel enabled |
| xfer_req | output | 1 | Channel active, requesting the transfer engine |
| pend_o | output | 1 | One request pending |
| wait_o | output | 1 | Waiting for end of programming |
| sync_flag | output | 1 | Synchronised transfer in progress |
| drop_flag | output | 1 | A request was dropped |
| load_stb | output | 1 | Reload working address set |
| act_stb | output | 1 | Activation event |
| deact_stb | output | 1 | Deactivation event |
| link_stb | output | 1 | Start the linked channel |
| link_ch | output | LINK_W | Channel number to start |
| mode_src | output | 2 | Latched source addressing mode |
| mode_dst | output | 2 | Latched destination addressing mode |
| prio_hi | output | 1 | Latched priority bit |

## Verification
The bench targets the single-deep pending slot. A design that overwrote the slot instead of flagging the drop would never raise `drop_flag`, and one that deactivated regardless of the slot would pulse `deact_stb` and lose a hardware request. It steps through all three granularities, including a frame event under block-sync that must be ignored, so granularity decoding that ignored `cfg_bs` would deactivate one event early. It checks the end-of-block branches (disable, reload, park in wait, chain to a neighbour) and the end-of-programming release from the parked state. It also checks a disable issued with a request pending, where a wrong design would revive the channel from its stale pending slot.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int SYNC_W    = 5;
  localparam int LINE_SPAN = 1 << SYNC_W;

  // Control word; field positions are fixed by software.
  typedef struct packed {
    logic [1:0]        dst_mode;
    logic [1:0]        src_mode;
    logic              end_prog;
    logic              compat;
    logic              rpt;
    logic              auto_init;
    logic              enable;
    logic              prio;
    logic              fs;
    logic [SYNC_W-1:0] sync;
  } chan_ctl_t;

  function automatic chan_ctl_t decode_ctl(input logic [15:0] w);
    return chan_ctl_t'(w);
  endfunction

  // True when the event matching the channel granularity has occurred.
  function automatic logic gran_hit(input chan_ctl_t c, input logic bs,
                                    input logic e_el, input logic e_fr,
                                    input logic e_bl);
    logic synced;
    synced = (c.sync != '0);
    return synced && ((!c.fs && !bs && e_el) ||
                      ( c.fs && !bs && e_fr) ||
                      ( c.fs &&  bs && e_bl));
  endfunction
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_chan_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINES-1:1]   req_lines,
  output logic [LINE_SPAN-1:0] line_lvl,
  output logic [LINE_SPAN-1:0] line_rise
);
  logic [LINE_SPAN-1:0] prev_q;

  // Line 0 means "no sync"; lines beyond N_LINES read as idle.
  assign line_lvl[0] = 1'b0;
  for (genvar i = 1; i < LINE_SPAN; i++) begin : g_pad
    if (i < N_LINES) begin : g_live
      assign line_lvl[i] = req_lines[i];
    end else begin : g_idle
      assign line_lvl[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_lvl;
  end

  assign line_rise = line_lvl & ~prev_q;
endmodule

// File: rtl/dma_chan_core.sv
module dma_chan_core
  import dma_chan_pkg::*;
#(
  parameter int LINK_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic [15:0]          ctl_wdata,
  input  logic                 link_in,
  input  logic                 cfg_bs,
  input  logic                 link_on,
  input  logic [LINK_W-1:0]    link_sel,
  input  logic [LINE_SPAN-1:0] line_lvl,
  input  logic [LINE_SPAN-1:0] line_rise,
  input  logic                 ev_elem,
  input  logic                 ev_frame,
  input  logic                 ev_block,
  input  logic                 stat_clr,
  output logic                 chan_en,
  output logic                 xfer_req,
  output logic                 pend_o,
  output logic                 wait_o,
  output logic                 sync_flag,
  output logic                 drop_flag,
  output logic                 load_stb,
  output logic                 act_stb,
  output logic                 deact_stb,
  output logic                 link_stb,
  output logic [LINK_W-1:0]    link_ch,
  output logic [1:0]           mode_src,
  output logic [1:0]           mode_dst,
  output logic                 prio_hi
);
  chan_ctl_t cfg_q, n_cfg;
  logic en_q, act_q, pend_q, wait_q, drop_q, syncf_q;
  logic n_en, n_act, n_pend, n_wait, n_drop, n_syncf;
  logic do_load, do_act, do_deact, do_link;
  logic deact_req, dis_req, en_go;
  logic load_q, actp_q, deactp_q, linkp_q;
  logic [LINK_W-1:0] link_ch_q;

  // Named event wires for the checks below.
  logic blk_end, req_edge;
  assign blk_end  = act_q && ev_block;
  assign req_edge = line_rise[cfg_q.sync];

  always_comb begin
    n_cfg    = cfg_q;
    n_en     = en_q;
    n_act    = act_q;
    n_pend   = pend_q;
    n_wait   = wait_q;
    n_drop   = drop_q && !stat_clr;
    do_load  = 1'b0;
    do_act   = 1'b0;
    do_deact = 1'b0;
    do_link  = 1'b0;
    dis_req  = 1'b0;
    en_go    = 1'b0;
    deact_req = act_q && gran_hit(cfg_q, cfg_bs, ev_elem, ev_frame, ev_block);

    // Stage 1: end-of-block policy.
    if (blk_end) begin
      if (cfg_q.compat) begin
        dis_req = 1'b1;
        do_link = link_on;
      end else if (!cfg_q.auto_init) begin
        dis_req = 1'b1;
      end else if (cfg_q.rpt || cfg_q.end_prog) begin
        do_load = 1'b1;
      end else begin
        n_wait    = 1'b1;
        deact_req = 1'b1;
      end
    end
    if (dis_req) begin
      n_en      = 1'b0;
      n_pend    = 1'b0;
      deact_req = 1'b1;
    end
    // Deactivation, consuming a pending request where allowed.
    if (deact_req && n_act) begin
      if (n_pend && !n_wait && n_en) begin
        n_pend = 1'b0;
        do_act = 1'b1;
      end else begin
        n_act    = 1'b0;
        do_deact = 1'b1;
      end
    end

    // Stage 2: hardware request on the selected line.
    if (n_en && req_edge) begin
      if (!n_act) begin
        n_act  = 1'b1;
        do_act = 1'b1;
      end else if (!n_pend) begin
        n_pend = 1'b1;
      end else begin
        n_drop = 1'b1;
      end
    end

    // Stage 3: software control and chained enable.
    if (ctl_wr) begin
      n_cfg = decode_ctl(ctl_wdata);
      if (n_cfg.enable && !n_en) begin
        en_go = 1'b1;
      end else if (!n_cfg.enable && n_en) begin
        n_en   = 1'b0;
        n_pend = 1'b0;
        if (n_act) begin
          n_act    = 1'b0;
          do_deact = 1'b1;
        end
      end
    end else if (link_in && !n_en) begin
      en_go = 1'b1;
    end
    if (en_go) begin
      n_en    = 1'b1;
      n_wait  = 1'b0;
      do_load = 1'b1;
      if (!n_act && (n_cfg.sync == '0 || line_lvl[n_cfg.sync])) begin
        n_act  = 1'b1;
        do_act = 1'b1;
      end
    end
    if (ctl_wr && n_cfg.end_prog && n_wait && n_en) begin
      n_wait = 1'b0;
      if (n_cfg.sync == '0 || n_pend) begin
        n_pend = 1'b0;
        if (!n_act) begin
          n_act  = 1'b1;
          do_act = 1'b1;
        end
      end
    end

    n_syncf = n_act && ((do_act && n_cfg.sync != '0) || (syncf_q && !do_deact));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      en_q      <= 1'b0;
      act_q     <= 1'b0;
      pend_q    <= 1'b0;
      wait_q    <= 1'b0;
      drop_q    <= 1'b0;
      syncf_q   <= 1'b0;
      load_q    <= 1'b0;
      actp_q    <= 1'b0;
      deactp_q  <= 1'b0;
      linkp_q   <= 1'b0;
      link_ch_q <= '0;
    end else begin
      cfg_q    <= n_cfg;
      en_q     <= n_en;
      act_q    <= n_act;
      pend_q   <= n_pend;
      wait_q   <= n_wait;
      drop_q   <= n_drop;
      syncf_q  <= n_syncf;
      load_q   <= do_load;
      actp_q   <= do_act;
      deactp_q <= do_deact;
      linkp_q  <= do_link;
      if (do_link) link_ch_q <= link_sel;
    end
  end

  assign chan_en   = en_q;
  assign xfer_req  = act_q;
  assign pend_o    = pend_q;
  assign wait_o    = wait_q;
  assign sync_flag = syncf_q;
  assign drop_flag = drop_q;
  assign load_stb  = load_q;
  assign act_stb   = actp_q;
  assign deact_stb = deactp_q;
  assign link_stb  = linkp_q;
  assign link_ch   = link_ch_q;
  assign mode_src  = cfg_q.src_mode;
  assign mode_dst  = cfg_q.dst_mode;
  assign prio_hi   = cfg_q.prio;

  // R2: an active channel is always an enabled one.
  p_act_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> en_q);
  // R2: a reload strobe has a cause in the previous cycle.
  p_load_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> $past(ctl_wr || link_in || ev_block));
  // R4: the drop flag holds until cleared.
  p_drop_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q && !stat_clr |=> drop_q);
  // R7: a chain request only follows a block end.
  p_link_after_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    linkp_q |-> $past(ev_block));
  // R10: sync flag only while active.
  p_sync_flag_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    syncf_q |-> act_q);
  // R11: disable write empties the channel in one cycle.
  p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_wdata[7] |=> !en_q && !act_q && !pend_q);
  // R11: no pending request survives on a disabled channel.
  p_pend_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> en_q);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int LINK_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [15:0]        ctl_wdata,
  input  logic               link_in,
  input  logic               cfg_bs,
  input  logic               link_on,
  input  logic [LINK_W-1:0]  link_sel,
  input  logic [N_LINES-1:1] req_lines,
  input  logic               ev_elem,
  input  logic               ev_frame,
  input  logic               ev_block,
  input  logic               stat_clr,
  output logic               chan_en,
  output logic               xfer_req,
  output logic               pend_o,
  output logic               wait_o,
  output logic               sync_flag,
  output logic               drop_flag,
  output logic               load_stb,
  output logic               act_stb,
  output logic               deact_stb,
  output logic               link_stb,
  output logic [LINK_W-1:0]  link_ch,
  output logic [1:0]         mode_src,
  output logic [1:0]         mode_dst,
  output logic               prio_hi
);
  logic [LINE_SPAN-1:0] line_lvl;
  logic [LINE_SPAN-1:0] line_rise;

  dma_req_sel #(.N_LINES(N_LINES)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_lines (req_lines),
    .line_lvl  (line_lvl),
    .line_rise (line_rise)
  );

  dma_chan_core #(.LINK_W(LINK_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .link_in   (link_in),
    .cfg_bs    (cfg_bs),
    .link_on   (link_on),
    .link_sel  (link_sel),
    .line_lvl  (line_lvl),
    .line_rise (line_rise),
    .ev_elem   (ev_elem),
    .ev_frame  (ev_frame),
    .ev_block  (ev_block),
    .stat_clr  (stat_clr),
    .chan_en   (chan_en),
    .xfer_req  (xfer_req),
    .pend_o    (pend_o),
    .wait_o    (wait_o),
    .sync_flag (sync_flag),
    .drop_flag (drop_flag),
    .load_stb  (load_stb),
    .act_stb   (act_stb),
    .deact_stb (deact_stb),
    .link_stb  (link_stb),
    .link_ch   (link_ch),
    .mode_src  (mode_src),
    .mode_dst  (mode_dst),
    .prio_hi   (prio_hi)
  );
endmodule

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb;
  localparam int N_LINES = 32;
  localparam int LINK_W  = 5;
  localparam int NROWS   = 30;
  localparam int WD_NS   = 4 * 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic link_in = 1'b0, cfg_bs = 1'b0, link_on = 1'b0;
  logic [LINK_W-1:0] link_sel = '0;
  logic [N_LINES-1:1] req_lines = '0;
  logic ev_elem = 1'b0, ev_frame = 1'b0, ev_block = 1'b0, stat_clr = 1'b0;
  logic chan_en, xfer_req, pend_o, wait_o, sync_flag, drop_flag;
  logic load_stb, act_stb, deact_stb, link_stb;
  logic [LINK_W-1:0] link_ch;
  logic [1:0] mode_src, mode_dst;
  logic prio_hi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_chan_ctrl #(.N_LINES(N_LINES), .LINK_W(LINK_W)) u_dut (.*);

  // Row: {wr, wdata[15:0], req[7:0], ev{blk,frm,elm}, exp{en,act,pend,wait,drop,load,actst,deact}, req_tag[3:0]}
  localparam logic [39:0] TBL [NROWS] = '{
    {1'b1, 16'h0083, 8'h00, 3'b000, 8'b1000_0100, 4'd2},  // R2 enable, line low: inactive
    {1'b0, 16'h0000, 8'h08, 3'b000, 8'b1100_0010, 4'd3},  // R3 edge activates
    {1'b0, 16'h0000, 8'h00, 3'b000, 8'b1100_0000, 4'd3},
    {1'b0, 16'h0000, 8'h08, 3'b000, 8'b1110_0000, 4'd3},  // R3 edge while active: pending
    {1'b0, 16'h0000, 8'h00, 3'b000, 8'b1110_0000, 4'd3},
    {1'b0, 16'h0000, 8'h08, 3'b000, 8'b1110_1000, 4'd4},  // R4 second pending: drop
    {1'b0, 16'h0000, 8'h00, 3'b001, 8'b1100_1010, 4'd6},  // R6 pending consumed
    {1'b0, 16'h0000, 8'h00, 3'b001, 8'b1000_1001, 4'd5},  // R5 element granularity
    {1'b0, 16'h0000, 8'h10, 3'b000, 8'b1000_1000, 4'd12}, // R12 other line ignored
    {1'b1, 16'h0000, 8'h00, 3'b000, 8'b0000_1000, 4'd11}, // R11 disable while inactive
    {1'b0, 16'h0000, 8'h08, 3'b000, 8'b0000_1000, 4'd12}, // R12 disabled ignores edge
    {1'b1, 16'h00A3, 8'h08, 3'b000, 8'b1100_1110, 4'd2},  // R2 line already high
    {1'b0, 16'h0000, 8'h00, 3'b001, 8'b1100_1000, 4'd5},  // R5 frame mode ignores element
    {1'b0, 16'h0000, 8'h00, 3'b010, 8'b1000_1001, 4'd5},  // R5 frame end deactivates
    {1'b1, 16'h0000, 8'h00, 3'b000, 8'b0000_1000, 4'd11},
    {1'b1, 16'h0080, 8'h00, 3'b000, 8'b1100_1110, 4'd2},  // R2 sync 0 activates at once
    {1'b0, 16'h0000, 8'h00, 3'b001, 8'b1100_1000, 4'd5},  // R5 unsynced keeps running
    {1'b0, 16'h0000, 8'h00, 3'b100, 8'b0000_1001, 4'd8},  // R8 no auto-init: disable
    {1'b1, 16'h0380, 8'h00, 3'b000, 8'b1100_1110, 4'd2},
    {1'b0, 16'h0000, 8'h00, 3'b100, 8'b1100_1100, 4'd8},  // R8 repeat: reload, keep going
    {1'b1, 16'h0000, 8'h00, 3'b000, 8'b0000_1001, 4'd11}, // R11 disable while active
    {1'b1, 16'h0183, 8'h00, 3'b000, 8'b1000_1100, 4'd2},
    {1'b0, 16'h0000, 8'h08, 3'b000, 8'b1100_1010, 4'd3},
    {1'b0, 16'h0000, 8'h08, 3'b100, 8'b1001_1001, 4'd8},  // R8 park in wait
    {1'b1, 16'h0983, 8'h00, 3'b000, 8'b1000_1000, 4'd9},  // R9 release, synced, nothing pending
    {1'b1, 16'h0000, 8'h00, 3'b000, 8'b0000_1000, 4'd11},
    {1'b1, 16'h0180, 8'h00, 3'b000, 8'b1100_1110, 4'd2},
    {1'b0, 16'h0000, 8'h00, 3'b100, 8'b1001_1001, 4'd8},
    {1'b1, 16'h0980, 8'h00, 3'b000, 8'b1100_1010, 4'd9},  // R9 release, sync 0: activates
    {1'b1, 16'h0000, 8'h00, 3'b000, 8'b0000_1001, 4'd11}
  };

  function automatic logic [7:0] snap();
    return {chan_en, xfer_req, pend_o, wait_o, drop_flag, load_stb, act_stb, deact_stb};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge; results are read at the next falling edge.
  task automatic step(input logic wr, input logic [15:0] wd, input logic [7:0] rq,
                      input logic [2:0] ev, input logic clr, input logic lk);
    ctl_wr    = wr;
    ctl_wdata = wd;
    req_lines = '0;
    req_lines[7:1] = rq[7:1];
    {ev_block, ev_frame, ev_elem} = ev;
    stat_clr  = clr;
    link_in   = lk;
    @(negedge clk);
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {24'd0, snap()}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {21'd0, sync_flag, link_stb, snap()}, 32'd0);

    for (int i = 0; i < NROWS; i++) begin
      logic [39:0] r;
      string msg;
      r = TBL[i];
      step(r[39], r[38:23], r[22:15], r[14:12], 1'b0, 1'b0);
      msg = $sformatf("R%0d table row %0d", r[3:0], i);
      check(msg, {24'd0, snap()}, {24'd0, r[11:4]});
    end

    // R4: clear of the sticky drop flag
    step(1'b0, 16'h0000, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R4 drop cleared", {31'd0, drop_flag}, 32'd0);

    // R10: sync flag follows a synchronised activation
    step(1'b1, 16'h0083, 8'h00, 3'b000, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'h08, 3'b000, 1'b0, 1'b0);
    check("R10 sync flag set", {30'd0, sync_flag, xfer_req}, 32'd3);
    step(1'b0, 16'h0000, 8'h08, 3'b001, 1'b0, 1'b0);
    check("R10 sync flag cleared", {30'd0, sync_flag, xfer_req}, 32'd0);

    // R11: disable with a request pending
    step(1'b0, 16'h0000, 8'h00, 3'b000, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'h08, 3'b000, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'h00, 3'b000, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'h08, 3'b000, 1'b0, 1'b0);
    check("R3 pending before disable", {31'd0, pend_o}, 32'd1);
    step(1'b1, 16'h0003, 8'h08, 3'b000, 1'b0, 1'b0);
    check("R11 disable with pending", {28'd0, chan_en, xfer_req, pend_o, deact_stb}, 32'h1);
    step(1'b0, 16'h0000, 8'h00, 3'b000, 1'b0, 1'b0);
    check("R11 no revival", {30'd0, xfer_req, act_stb}, 32'd0);

    // R5: block granularity
    cfg_bs = 1'b1;
    step(1'b1, 16'h03A3, 8'h00, 3'b000, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'h08, 3'b000, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'h08, 3'b010, 1'b0, 1'b0);
    check("R5 frame ignored under block sync", {31'd0, xfer_req}, 32'd1);
    step(1'b0, 16'h0000, 8'h08, 3'b100, 1'b0, 1'b0);
    check("R5 block end deactivates", {28'd0, chan_en, xfer_req, load_stb, deact_stb}, 32'b1011);
    step(1'b1, 16'h0000, 8'h00, 3'b000, 1'b0, 1'b0);
    cfg_bs = 1'b0;

    // R7: compatibility-disable and chaining
    link_on  = 1'b1;
    link_sel = 5'd9;
    step(1'b1, 16'h0480, 8'h00, 3'b000, 1'b0, 1'b0);
    check("R2 compat channel active", {31'd0, xfer_req}, 32'd1);
    step(1'b0, 16'h0000, 8'h00, 3'b100, 1'b0, 1'b0);
    check("R7 self disable and link", {24'd0, chan_en, xfer_req, link_stb, link_ch}, {24'd0, 3'b001, 5'd9});
    step(1'b0, 16'h0000, 8'h00, 3'b000, 1'b0, 1'b0);
    check("R7 link strobe one cycle", {31'd0, link_stb}, 32'd0);

    // R2: enable through the chain input
    step(1'b0, 16'h0000, 8'h00, 3'b000, 1'b0, 1'b1);
    check("R2 link enable", {29'd0, chan_en, xfer_req, load_stb}, 32'b111);
    step(1'b1, 16'h0000, 8'h00, 3'b000, 1'b0, 1'b0);
    link_on = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule